// File: doc/BRIEF.md
# UART Diagnostic Loopback Router

This block sits between one serial channel's transmitter, its receiver, the two line pins and the host's receive data path. A two-bit mode request chooses one of three routings: normal operation, local loopback (the transmitter's serial stream is fed straight back into the receiver while the line output idles at mark), or remote loopback (line input is retimed and echoed back onto the line output, while the host sees nothing received).

The block steers the bit-rate clock enables as well as the data. In local loopback the receiver runs from the transmit bit strobe. In remote loopback the transmitter timing runs from the receive bit strobe. A new mode request is taken only while both the transmitter and the receiver report that no character is in flight, so a frame is never cut in half. The line input passes through a reset-to-mark synchronizer before any use.

Top module: `loopback_router`

## Requirements
- R1: After reset the active mode is normal (`active_mode_o` = 2'b00), the synchronizer stages and the echo register hold 1 (mark).
- R2: Request codes 2'b00 and 2'b01 both select normal mode (reported as 2'b00): `txd_o` equals `tx_ser_i`, `rx_ser_o` is the synchronized line input, `rx_bclk_o` equals `rx_bclk_i` and `tx_bclk_o` equals `tx_bclk_i`.
- R3: Request code 2'b10 selects local loopback (reported as 2'b10): `rx_ser_o` equals `tx_ser_i` and `rx_bclk_o` equals `tx_bclk_i`.
- R4: In local loopback `txd_o` is 1 and `rxd_i` has no effect on `rx_ser_o` or `txd_o`.
- R5: Request code 2'b11 selects remote loopback (reported as 2'b11): `txd_o` is a register that, on each cycle with `rx_bclk_i` high, takes the synchronized line input, and `tx_bclk_o` equals `rx_bclk_i`.
- R6: In remote loopback `host_valid_o` is 0, `host_data_o` is all zeros and `host_err_o` is all zeros whatever the receiver presents.
- R7: Outside remote loopback the host outputs pass `rx_valid_i`, `rx_data_i` and `rx_err_i` through unchanged.
- R8: The active mode takes the decoded request on a clock edge only when `tx_busy_i` and `rx_busy_i` are both 0; otherwise it keeps its value.
- R9: The synchronized line input is `rxd_i` delayed by exactly SYNC_STAGES clock cycles.
- R10: While the active mode is not remote, the echo register is reloaded with 1 every cycle, so remote loopback always starts from mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_req_i | input | 2 | Requested routing mode |
| tx_busy_i | input | 1 | Transmitter has a character in flight |
| rx_busy_i | input | 1 | Receiver has a character in flight |
| tx_ser_i | input | 1 | Serial output of the transmitter |
| tx_bclk_i | input | 1 | Transmit bit-rate enable from the rate generator |
| rx_bclk_i | input | 1 | Receive bit-rate enable from the rate generator |
| rxd_i | input | 1 | Line input pin |
| rx_valid_i | input | 1 | Receiver has a completed character |
| rx_data_i | input | DATA_W | Receiver character |
| rx_err_i | input | ERR_W | Receiver error flags |
| txd_o | output | 1 | Line output pin |
| rx_ser_o | output | 1 | Serial input to the receiver |
| rx_bclk_o | output | 1 | Bit-rate enable to the receiver |
| tx_bclk_o | output | 1 | Bit-rate enable to the transmitter |
| host_valid_o | output | 1 | Character valid toward the host |
| host_data_o | output | DATA_W | Character toward the host |
| host_err_o | output | ERR_W | Error flags toward the host |
| active_mode_o | output | 2 | Mode currently in force |

## Verification
A mode register that loads at the wrong moment shows on `active_mode_o` and on every steered pin in the very next cycle, so mode requests are issued while the busy flags toggle and the bench compares every port on every clock. A wrong synchronizer depth or a stale echo register shows on `rx_ser_o` or `txd_o` within SYNC_STAGES cycles of an edge on `rxd_i`, which random line data under frequent strobes exposes quickly. Host leakage in remote mode shows the first time the receiver raises valid or an error flag.

// File: rtl/lb_pkg.sv
package lb_pkg;
  typedef enum logic [1:0] {
    LB_NORMAL = 2'b00,
    LB_LOCAL  = 2'b10,
    LB_REMOTE = 2'b11
  } lb_mode_e;

  function automatic lb_mode_e lb_decode(input logic [1:0] code);
    case (code)
      2'b10:   return LB_LOCAL;
      2'b11:   return LB_REMOTE;
      default: return LB_NORMAL;
    endcase
  endfunction
endpackage

// File: rtl/lb_mode_ctl.sv
module lb_mode_ctl
  import lb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] req_i,
  input  logic       tx_busy_i,
  input  logic       rx_busy_i,
  output lb_mode_e   mode_o
);
  lb_mode_e mode_q;
  logic     at_boundary;

  assign at_boundary = !tx_busy_i && !rx_busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          mode_q <= LB_NORMAL;
    else if (at_boundary) mode_q <= lb_decode(req_i);
  end

  assign mode_o = mode_q;

  p_hold_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_busy_i || rx_busy_i) |=> $stable(mode_q));
  p_legal_mode_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q != 2'b01);
endmodule

// File: rtl/lb_sync.sv
module lb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] st_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q[0] <= 1'b1;
        else         st_q[0] <= d_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q[i] <= 1'b1;
        else         st_q[i] <= st_q[i-1];
      end
    end
  end

  assign q_o = st_q[STAGES-1];

  p_first_stage_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> st_q[0] == $past(d_i));
endmodule

// File: rtl/lb_echo.sv
module lb_echo (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic strobe_i,
  input  logic d_i,
  output logic q_o
);
  logic echo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       echo_q <= 1'b1;
    else if (!en_i)    echo_q <= 1'b1;
    else if (strobe_i) echo_q <= d_i;
  end

  assign q_o = echo_q;

  p_echo_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !strobe_i) |=> $stable(echo_q));
  p_echo_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> echo_q);
endmodule

// File: rtl/loopback_router.sv
module loopback_router
  import lb_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ERR_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_req_i,
  input  logic              tx_busy_i,
  input  logic              rx_busy_i,
  input  logic              tx_ser_i,
  input  logic              tx_bclk_i,
  input  logic              rx_bclk_i,
  input  logic              rxd_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic [ERR_W-1:0]  rx_err_i,
  output logic              txd_o,
  output logic              rx_ser_o,
  output logic              rx_bclk_o,
  output logic              tx_bclk_o,
  output logic              host_valid_o,
  output logic [DATA_W-1:0] host_data_o,
  output logic [ERR_W-1:0]  host_err_o,
  output logic [1:0]        active_mode_o
);
  lb_mode_e mode;
  logic     rxd_s;
  logic     echo;
  logic     is_local, is_remote;

  lb_mode_ctl u_mode (
    .clk_i, .rst_ni,
    .req_i     (mode_req_i),
    .tx_busy_i,
    .rx_busy_i,
    .mode_o    (mode)
  );

  lb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni,
    .d_i (rxd_i),
    .q_o (rxd_s)
  );

  assign is_local  = (mode == LB_LOCAL);
  assign is_remote = (mode == LB_REMOTE);

  lb_echo u_echo (
    .clk_i, .rst_ni,
    .en_i     (is_remote),
    .strobe_i (rx_bclk_i),
    .d_i      (rxd_s),
    .q_o      (echo)
  );

  always_comb begin
    unique case (mode)
      LB_LOCAL:  txd_o = 1'b1;
      LB_REMOTE: txd_o = echo;
      default:   txd_o = tx_ser_i;
    endcase
  end

  assign rx_ser_o  = is_local  ? tx_ser_i  : rxd_s;
  assign rx_bclk_o = is_local  ? tx_bclk_i : rx_bclk_i;
  assign tx_bclk_o = is_remote ? rx_bclk_i : tx_bclk_i;

  // remote echo keeps received traffic and errors away from the host
  assign host_valid_o  = rx_valid_i && !is_remote;
  assign host_data_o   = is_remote ? '0 : rx_data_i;
  assign host_err_o    = is_remote ? '0 : rx_err_i;
  assign active_mode_o = mode;

  p_remote_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_mode_o == 2'b11) |-> (!host_valid_o && host_err_o == '0 && host_data_o == '0));
  p_local_mark_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_mode_o == 2'b10) |-> txd_o);
  p_local_clk_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_mode_o == 2'b10) |-> (rx_bclk_o == tx_bclk_i && rx_ser_o == tx_ser_i));
  p_remote_clk_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_mode_o == 2'b11) |-> (tx_bclk_o == rx_bclk_i));
  p_pass_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_mode_o != 2'b11) |-> (host_valid_o == rx_valid_i && host_err_o == rx_err_i));
endmodule

// File: tb/test_loopback_router.sv
module test_loopback_router;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8;
  localparam int ERR_W  = 3;
  localparam int SYNC   = 2;

  logic clk = 0, rst_n = 0;
  logic [1:0] mode_req = 0;
  logic tx_busy = 0, rx_busy = 0, tx_ser = 1, tx_bclk = 0, rx_bclk = 0, rxd = 1;
  logic rx_valid = 0;
  logic [DATA_W-1:0] rx_data = 0;
  logic [ERR_W-1:0]  rx_err = 0;
  logic txd, rx_ser, rx_bclk_o, tx_bclk_o, host_valid;
  logic [DATA_W-1:0] host_data;
  logic [ERR_W-1:0]  host_err;
  logic [1:0] active_mode;

  int total = 0, bad = 0;
  bit run_cmp = 0;

  // reference state
  logic [1:0] m_mode;
  logic       m_echo;
  logic       m_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  loopback_router #(.DATA_W(DATA_W), .ERR_W(ERR_W), .SYNC_STAGES(SYNC)) i_loopback_router (
    .clk_i(clk), .rst_ni(rst_n), .mode_req_i(mode_req), .tx_busy_i(tx_busy), .rx_busy_i(rx_busy),
    .tx_ser_i(tx_ser), .tx_bclk_i(tx_bclk), .rx_bclk_i(rx_bclk), .rxd_i(rxd),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_err_i(rx_err),
    .txd_o(txd), .rx_ser_o(rx_ser), .rx_bclk_o(rx_bclk_o), .tx_bclk_o(tx_bclk_o),
    .host_valid_o(host_valid), .host_data_o(host_data), .host_err_o(host_err),
    .active_mode_o(active_mode));

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s at %0t: got=%h exp=%h", req, $time, got, exp);
    end
  endtask

  function automatic logic [1:0] dec(input logic [1:0] c);
    return (c[1]) ? c : 2'b00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 2'b00; m_echo = 1'b1;
      m_q = {};
      for (int i = 0; i < SYNC; i++) m_q.push_back(1'b1);
    end else begin
      logic rs;
      rs = m_q[0];
      if (m_mode != 2'b11) m_echo = 1'b1;      // R10
      else if (rx_bclk)    m_echo = rs;        // R5
      void'(m_q.pop_front());
      m_q.push_back(rxd);                      // R9
      if (!tx_busy && !rx_busy) m_mode = dec(mode_req);  // R8
    end
  end

  task automatic compare_all();
    logic rs, e_txd;
    string tg;
    rs = m_q[0];
    tg = (m_mode == 2'b10) ? "R3/R4" : (m_mode == 2'b11) ? "R5/R6" : "R2/R7";
    e_txd = (m_mode == 2'b10) ? 1'b1 : (m_mode == 2'b11) ? m_echo : tx_ser;
    chk("R8 mode", 16'(active_mode), 16'(m_mode));
    chk({tg, " txd"}, 16'(txd), 16'(e_txd));
    chk({tg, " rx_ser R9"}, 16'(rx_ser), 16'((m_mode == 2'b10) ? tx_ser : rs));
    chk({tg, " rx_bclk"}, 16'(rx_bclk_o), 16'((m_mode == 2'b10) ? tx_bclk : rx_bclk));
    chk({tg, " tx_bclk"}, 16'(tx_bclk_o), 16'((m_mode == 2'b11) ? rx_bclk : tx_bclk));
    chk({tg, " host_valid"}, 16'(host_valid), 16'(rx_valid && m_mode != 2'b11));
    chk({tg, " host_data"}, 16'(host_data), 16'((m_mode == 2'b11) ? '0 : rx_data));
    chk({tg, " host_err"}, 16'(host_err), 16'((m_mode == 2'b11) ? '0 : rx_err));
  endtask

  always @(negedge clk) if (run_cmp) compare_all();

  task automatic rand_inputs(input int busy_pct);
    tx_busy  = ($urandom_range(99) < busy_pct);
    rx_busy  = ($urandom_range(99) < busy_pct);
    tx_ser   = $urandom_range(1);
    tx_bclk  = ($urandom_range(3) == 0);
    rx_bclk  = ($urandom_range(2) == 0);
    rxd      = $urandom_range(1);
    rx_valid = $urandom_range(1);
    rx_data  = DATA_W'($urandom);
    rx_err   = ERR_W'($urandom);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1 mode", 16'(active_mode), 16'h0);
    chk("R1 sync mark", 16'(rx_ser), 16'h1);
    tx_ser = 0; #1;
    chk("R1 txd follows tx", 16'(txd), 16'h0);
    run_cmp = 1;
    // R8 directed: request local while busy, must not switch
    tx_busy = 1; mode_req = 2'b10;
    repeat (4) @(negedge clk);
    chk("R8 held while busy", 16'(active_mode), 16'h0);
    tx_busy = 0; rx_busy = 1;
    repeat (2) @(negedge clk);
    chk("R8 held rx busy", 16'(active_mode), 16'h0);
    rx_busy = 0;
    @(negedge clk);
    chk("R3 local entered", 16'(active_mode), 16'h2);
    // R4: toggling rxd has no effect in local mode
    for (int i = 0; i < 8; i++) begin
      rxd = i[0]; tx_ser = 1'b1;
      @(negedge clk);
      chk("R4 rxd ignored", 16'({txd, rx_ser}), 16'h3);
    end
    // R2: code 01 is normal
    mode_req = 2'b01;
    @(negedge clk);
    chk("R2 code 01 normal", 16'(active_mode), 16'h0);
    // R10: remote starts from mark
    mode_req = 2'b11; rx_bclk = 0;
    @(negedge clk);
    chk("R10 echo mark on entry", 16'(txd), 16'h1);
    // random phases
    for (int ph = 0; ph < 6; ph++) begin
      for (int c = 0; c < 1500; c++) begin
        rand_inputs((ph % 2) ? 70 : 20);
        if ($urandom_range(40) == 0) mode_req = 2'($urandom);
        @(negedge clk);
      end
    end
    run_cmp = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule